// File: doc/BRIEF.md
# Bus Break Controller with Data-Bus Injection

This block stalls an 8-bit microprocessor on selected read cycles so that an operator can step through a program or replace the byte the processor is about to read. It watches the processor's active-low bus strobes. When a read cycle of an armed kind begins, it pulls the active-low wait output low and the processor freezes mid-cycle. Three kinds can be armed, in any combination: an opcode fetch, a memory read and an I/O read.

While the processor is frozen, a byte can be offered on a valid/ready input. The byte is copied into a holding register and driven onto the data bus through an output enable. Outside a break the enable stays low, so the bus driver is high-impedance. A resume pulse releases the wait output and the processor completes its read. If a byte was loaded, the processor takes that byte. The enable drops on its own once the read strobe returns high, so the byte cannot leak into a later cycle.

The injection input follows valid/ready rules. `inj_ready` is high only while a break holds the processor. A byte transfers on a clock edge where `inj_valid` and `inj_ready` are both high. While `inj_ready` is low, an offer is not taken and changes nothing. The source may hold `inj_valid` high for as long as it likes.

Top module: `brk_wait_inject`

## Requirements
- R1: After reset `wait_n` is 1, `bus_oe` is 0, `bus_dout` is 0 and `inj_ready` is 0.
- R2: Strobes are sampled through SYNC_STAGES flops (default 2). The break takes effect on the (SYNC_STAGES+1)-th rising edge after an armed event appears, and `wait_n` goes low then.
- R3: The event kinds and their arm bits are as follows. Opcode fetch is m1, mreq and rd all low, armed by `arm_mask[0]`. Memory read is mreq and rd low with m1 high, armed by `arm_mask[1]`. I/O read is iorq and rd low with m1 high, armed by `arm_mask[2]`. Each kind breaks when its own bit is set.
- R4: None of these produces a break: a read kind whose arm bit is clear, any write cycle, or an interrupt acknowledge (m1 and iorq low, rd high). In each case `wait_n` stays 1.
- R5: `inj_ready` is 1 only while a break holds the processor. An offer made outside a break is ignored. A break without an accepted byte never raises `bus_oe`.
- R6: One clock after a transfer, `bus_oe` is 1 and `bus_dout` equals the transferred byte, and `wait_n` stays 0. A second transfer during the same break replaces the byte.
- R7: A `resume` pulse during a break raises `wait_n` one clock later. A loaded byte stays driven after that.
- R8: After the read strobe returns high, `bus_oe` falls SYNC_STAGES edges later, on the same edge where the synchronized strobe rises.
- R9: A break fires only at the start of an event. Two cases never break: arming after an event has begun, and any moment of a bus cycle after a break on that cycle has been released.
- R10: `bus_oe` is 0 whenever the synchronized read strobe is high or the synchronized write strobe is low.
- R11: A transfer and a `resume` may arrive on the same edge of a break. In that case the byte is taken and driven, and `wait_n` rises on that edge.
- R12: The read strobe may return high during a break without any resume. Then `wait_n` rises SYNC_STAGES+1 edges later and the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_m1_n | input | 1 | Opcode-fetch cycle marker, active low |
| cpu_mreq_n | input | 1 | Memory request strobe, active low |
| cpu_iorq_n | input | 1 | I/O request strobe, active low |
| cpu_rd_n | input | 1 | Read strobe, active low |
| cpu_wr_n | input | 1 | Write strobe, active low |
| arm_mask | input | 3 | Arm bits: [0] fetch, [1] memory read, [2] I/O read |
| resume | input | 1 | Release the held processor (pulse) |
| inj_valid | input | 1 | Injection byte offered |
| inj_ready | output | 1 | Injection byte can be taken (break in progress) |
| inj_data | input | DATA_W | Injection byte |
| wait_n | output | 1 | Wait request to the processor, active low |
| bus_dout | output | DATA_W | Byte for the data bus (0 when not enabled) |
| bus_oe | output | 1 | Tri-state enable for `bus_dout` |

## Verification
Two functions can land on the same edge: taking an injected byte, and releasing the wait on resume. The bench provokes this by raising `inj_valid` and `resume` together on the first cycle after a break. It judges the outcome from the ports on the next cycle: `wait_n` must be high, `bus_oe` high, and `bus_dout` must equal the offered byte. This case is part of a sweep over every arm mask, six bus-cycle kinds and four injection patterns. The same sweep also moves the read strobe away while a byte is driven, and expects the enable to drop before the hold is lifted.

// File: rtl/bbk_pkg.sv
package bbk_pkg;
  localparam int NUM_KINDS  = 3;
  localparam int KIND_FETCH = 0;
  localparam int KIND_MEMRD = 1;
  localparam int KIND_IORD  = 2;
  localparam int NUM_STROBES = 5;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HOLD,
    ST_INJECT,
    ST_RELEASE
  } brk_state_t;

  // strobes after polarity flip: 1 means asserted
  typedef struct packed {
    logic m1;
    logic mreq;
    logic iorq;
    logic rd;
    logic wr;
  } bus_strobe_t;
endpackage

// File: rtl/bbk_sync.sv
module bbk_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RESET_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign q = d;
    end else begin : g_chain
      logic [STAGES-1:0][W-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain <= {STAGES{RESET_VAL}};
        end else begin
          chain[0] <= d;
          for (int i = 1; i < STAGES; i++) begin
            chain[i] <= chain[i-1];
          end
        end
      end
      assign q = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/bbk_event_decode.sv
module bbk_event_decode
  import bbk_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  bus_strobe_t          strb,
  input  logic [NUM_KINDS-1:0] arm,
  output logic                 fire,
  output logic                 rd_active,
  output logic                 wr_active
);
  logic [NUM_KINDS-1:0] hit;
  logic [NUM_KINDS-1:0] hit_q;
  logic [NUM_KINDS-1:0] start;

  // cycle classification; m1 separates a fetch from a plain read,
  // and an interrupt acknowledge (m1 with iorq) carries no rd
  always_comb begin
    hit = '0;
    hit[KIND_FETCH] = strb.m1  & strb.mreq & strb.rd;
    hit[KIND_MEMRD] = ~strb.m1 & strb.mreq & strb.rd;
    hit[KIND_IORD]  = ~strb.m1 & strb.iorq & strb.rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit_q <= '0;
    else        hit_q <= hit;
  end

  // a kind can only trigger on the edge where it begins (R9)
  generate
    for (genvar k = 0; k < NUM_KINDS; k++) begin : g_start
      assign start[k] = hit[k] & ~hit_q[k] & arm[k];
    end
  endgenerate

  assign fire      = |start;
  assign rd_active = strb.rd;
  assign wr_active = strb.wr;

  a_r9_single_start: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !fire);
endmodule

// File: rtl/bbk_hold_reg.sv
module bbk_hold_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    dout <= '0;
    else if (load) dout <= din;
  end
endmodule

// File: rtl/bbk_ctrl.sv
module bbk_ctrl
  import bbk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fire,
  input  logic       rd_active,
  input  logic       wr_active,
  input  logic       resume,
  input  logic       inj_valid,
  output logic       inj_ready,
  output logic       accept,
  output logic       wait_n,
  output logic       drive_en,
  output brk_state_t state
);
  brk_state_t state_nx;
  logic       loaded;
  logic       holding;

  assign holding   = (state == ST_HOLD) || (state == ST_INJECT);
  assign inj_ready = holding;
  assign accept    = inj_valid & inj_ready;
  assign wait_n    = ~holding;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:    if (fire) state_nx = ST_HOLD;
      ST_HOLD: begin
        if (!rd_active)  state_nx = ST_IDLE;      // R12 strobe lost
        else if (resume) state_nx = ST_RELEASE;   // R11 resume wins state
        else if (accept) state_nx = ST_INJECT;
      end
      ST_INJECT: begin
        if (!rd_active)  state_nx = ST_IDLE;
        else if (resume) state_nx = ST_RELEASE;
      end
      ST_RELEASE: if (!rd_active) state_nx = ST_IDLE;
      default:    state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      loaded <= 1'b0;
    end else begin
      state  <= state_nx;
      loaded <= (state_nx != ST_IDLE) && (loaded || accept);
    end
  end

  // enable only inside a read, never during a write (R10)
  assign drive_en = loaded && ((state == ST_INJECT) || (state == ST_RELEASE))
                    && rd_active && !wr_active;

  a_r2_fire_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && state == ST_IDLE) |=> !wait_n);
  a_r5_ready_in_break: assert property (@(posedge clk) disable iff (!rst_n)
    inj_ready |-> !wait_n);
  a_r6_accept_drives: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && rd_active) |=> (state == ST_INJECT || state == ST_RELEASE));
  a_r7_resume_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (holding && resume && rd_active) |=> wait_n);
  a_r9_no_rebreak: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RELEASE) |=> (state != ST_HOLD));
endmodule

// File: rtl/brk_wait_inject.sv
module brk_wait_inject
  import bbk_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_m1_n,
  input  logic              cpu_mreq_n,
  input  logic              cpu_iorq_n,
  input  logic              cpu_rd_n,
  input  logic              cpu_wr_n,
  input  logic [2:0]        arm_mask,
  input  logic              resume,
  input  logic              inj_valid,
  output logic              inj_ready,
  input  logic [DATA_W-1:0] inj_data,
  output logic              wait_n,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_oe
);
  logic [NUM_STROBES-1:0] raw_n;
  logic [NUM_STROBES-1:0] sync_n;
  bus_strobe_t            strb;
  logic                   fire;
  logic                   rd_active;
  logic                   wr_active;
  logic                   accept;
  logic                   drive_en;
  logic [DATA_W-1:0]      held;
  brk_state_t             state;

  assign raw_n = {cpu_m1_n, cpu_mreq_n, cpu_iorq_n, cpu_rd_n, cpu_wr_n};

  bbk_sync #(
    .W(NUM_STROBES), .STAGES(SYNC_STAGES), .RESET_VAL({NUM_STROBES{1'b1}})
  ) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_n), .q(sync_n)
  );

  assign strb = bus_strobe_t'(~sync_n);

  bbk_event_decode u_decode (
    .clk(clk), .rst_n(rst_n), .strb(strb), .arm(arm_mask),
    .fire(fire), .rd_active(rd_active), .wr_active(wr_active)
  );

  bbk_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .fire(fire), .rd_active(rd_active),
    .wr_active(wr_active), .resume(resume), .inj_valid(inj_valid),
    .inj_ready(inj_ready), .accept(accept), .wait_n(wait_n),
    .drive_en(drive_en), .state(state)
  );

  bbk_hold_reg #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(accept), .din(inj_data), .dout(held)
  );

  assign bus_oe   = drive_en;
  assign bus_dout = drive_en ? held : '0;

  a_r8_oe_follows_rd: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_n[1]) |-> !bus_oe);
  a_r10_no_drive_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_n[0] |-> !bus_oe);
  a_r1_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> (!inj_ready && !bus_oe));
endmodule

// File: tb/brk_wait_inject_bench.sv
`timescale 1ns/1ps
module brk_wait_inject_bench;
  localparam int S   = 2;
  localparam int LAT = S + 1;
  localparam int WATCHDOG_CYC = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       m1_n = 1, mreq_n = 1, iorq_n = 1, rd_n = 1, wr_n = 1;
  logic [2:0] arm = '0;
  logic       resume = 0, inj_valid = 0;
  logic [7:0] inj_data = '0;
  logic       inj_ready, wait_n, bus_oe;
  logic [7:0] bus_dout;

  int n_checks = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  brk_wait_inject #(.DATA_W(8), .SYNC_STAGES(S)) u_brk_wait_inject (
    .clk(clk), .rst_n(rst_n), .cpu_m1_n(m1_n), .cpu_mreq_n(mreq_n),
    .cpu_iorq_n(iorq_n), .cpu_rd_n(rd_n), .cpu_wr_n(wr_n),
    .arm_mask(arm), .resume(resume), .inj_valid(inj_valid),
    .inj_ready(inj_ready), .inj_data(inj_data), .wait_n(wait_n),
    .bus_dout(bus_dout), .bus_oe(bus_oe)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive_event(input int ev);
    case (ev)
      0: begin m1_n = 0; mreq_n = 0; rd_n = 0; end
      1: begin mreq_n = 0; rd_n = 0; end
      2: begin iorq_n = 0; rd_n = 0; end
      3: begin mreq_n = 0; wr_n = 0; end
      4: begin iorq_n = 0; wr_n = 0; end
      default: begin m1_n = 0; iorq_n = 0; end
    endcase
  endtask

  task automatic end_event();
    m1_n = 1; mreq_n = 1; iorq_n = 1; rd_n = 1; wr_n = 1;
  endtask

  // rd strobe rises: enable off after S edges (R8)
  task automatic finish_driven(input logic [7:0] a);
    end_event();
    if (S > 0) begin
      tick(S - 1);
      chk("R8 oe before sync", bus_oe, 1);
      chk("R8 dout before sync", bus_dout, a);
    end
    tick(1);
    chk("R8 oe off", bus_oe, 0);
    chk("R8 dout zero", bus_dout, 0);
    tick(1);
    chk("R9 no rebreak", wait_n, 1);
  endtask

  initial begin
    @(negedge clk);
    #1;
    chk("R1 wait", wait_n, 1);
    chk("R1 oe", bus_oe, 0);
    chk("R1 ready", inj_ready, 0);
    chk("R1 dout", bus_dout, 0);
    tick(2);
    rst_n = 1;
    tick(2);
    chk("R1 wait after", wait_n, 1);

    for (int mask = 0; mask < 8; mask++) begin
      for (int ev = 0; ev < 6; ev++) begin
        for (int v = 0; v < 4; v++) begin
          logic       brk;
          logic [7:0] a;
          logic [7:0] b;
          brk = (ev < 3) && mask[ev];
          a = 8'((mask * 37 + ev * 11 + v * 5 + 1) & 255);
          b = ~a;
          arm = 3'(mask);
          tick(1);
          if (v == 0) begin
            inj_valid = 1; inj_data = a;
            #1;
            chk("R5 ready idle", inj_ready, 0);
            tick(1);
            inj_valid = 0;
            chk("R5 ignored offer", bus_oe, 0);
          end
          drive_event(ev);
          if (v == 1 && ev < 3 && !brk) begin
            tick(S + 1);
            arm = 3'b111;
            tick(LAT + 2);
            chk("R9 late arm", wait_n, 1);
            end_event();
            tick(LAT + 2);
            continue;
          end
          tick(LAT);
          chk(brk ? "R2 R3 break" : "R4 no break", wait_n, brk ? 0 : 1);
          if (!brk) begin
            tick(3);
            chk("R4 still idle", wait_n, 1);
            chk("R4 ready", inj_ready, 0);
            chk("R4 oe", bus_oe, 0);
            end_event();
            tick(LAT + 2);
            continue;
          end
          chk("R5 ready in break", inj_ready, 1);
          chk("R5 no drive w/o data", bus_oe, 0);
          case (v)
            0: begin
              tick(2);
              chk("R5 oe held", bus_oe, 0);
              resume = 1; tick(1); resume = 0;
              chk("R7 released", wait_n, 1);
              chk("R5 oe released", bus_oe, 0);
              tick(3);
              chk("R9 no rebreak", wait_n, 1);
              end_event();
              tick(LAT + 2);
            end
            1: begin
              inj_valid = 1; inj_data = a; tick(1); inj_valid = 0;
              chk("R6 oe", bus_oe, 1);
              chk("R6 dout", bus_dout, a);
              chk("R6 wait held", wait_n, 0);
              tick(2);
              chk("R6 still held", wait_n, 0);
              resume = 1; tick(1); resume = 0;
              chk("R7 released", wait_n, 1);
              chk("R7 oe kept", bus_oe, 1);
              chk("R7 dout kept", bus_dout, a);
              tick(4);
              chk("R9 no rebreak", wait_n, 1);
              finish_driven(a);
              tick(LAT);
            end
            2: begin
              inj_valid = 1; inj_data = a; resume = 1;
              tick(1);
              inj_valid = 0; resume = 0;
              chk("R11 wait", wait_n, 1);
              chk("R11 oe", bus_oe, 1);
              chk("R11 dout", bus_dout, a);
              finish_driven(a);
              tick(LAT);
            end
            default: begin
              inj_valid = 1; inj_data = a; tick(1);
              chk("R6 first", bus_dout, a);
              inj_data = b; tick(1); inj_valid = 0;
              chk("R6 reload", bus_dout, b);
              wr_n = 0;
              tick(S);
              chk("R10 oe in write", bus_oe, 0);
              wr_n = 1;
              tick(S);
              chk("R10 oe back", bus_oe, 1);
              end_event();
              tick(S);
              chk("R8 oe abort", bus_oe, 0);
              chk("R12 still held", wait_n, 0);
              tick(1);
              chk("R12 released", wait_n, 1);
              chk("R12 ready", inj_ready, 0);
              tick(LAT);
            end
          endcase
        end
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule